// File: doc/BRIEF.md
# I2C SCL rate generator

This block produces the bus-clock timing for an I2C master from a fast system clock. A 9-bit clock-control word holds two fields. A prescale field turns the system clock into a one-cycle enable, the internal tick. A stretch field sets how many ticks one SCL period lasts. The period is not a plain divide: it adds a fixed overhead of 20 ticks, 8 ticks for each step of the stretch field, and a compensation term that covers the SCL edge times and the internal path delay of this instance. That term is a synthesis parameter.

The master drives `run` high to request clocking. The block returns the SCL level and four single-cycle strobes: the SCL fall, the SCL rise, the point where SDA may change (inside the low phase) and the point where SDA is sampled (inside the high phase). All logic runs on the system clock. A new control word can be presented at any time. While the generator is idle it is adopted at once. While the generator is running it waits for the start of the next period, so a phase in progress is never stretched or cut short.

Top module: `scl_rate_gen`

## Requirements
- R1: The control word `cfg_in` carries the stretch value `s` in bits [8:3] and the prescale value `d` in bits [2:0]. The phase counters advance once every `d+1` system clock cycles.
- R2: An SCL period lasts `P = 20 + 8*s + COMP_F` ticks (COMP_F default 6), that is `P*(d+1)` system cycles from one `scl_fall` strobe to the next.
- R3: The low phase lasts `L = floor(P/2)` ticks and the high phase `P-L` ticks. `scl_fall` pulses in the first cycle with `scl_o` low and `scl_rise` pulses in the first cycle with `scl_o` high. The rise follows the fall by `L*(d+1)` system cycles.
- R4: `sda_chg` pulses `floor(L/2)` ticks after `scl_fall` while SCL is low. `smp_stb` pulses `floor((P-L)/2)` ticks after `scl_rise` while SCL is high.
- R5: All four strobes are one system cycle wide, and no two are ever high in the same cycle.
- R6: From idle, the first `scl_fall` appears `d+1` system cycles after the first clock edge that samples `run` high.
- R7: When `run` is low at the end of a high phase, the generator goes idle: `scl_o` stays high and no strobe pulses. A period in progress, including its sample strobe, always completes.
- R8: A control word loaded with `cfg_load` while the generator is running leaves the current period unchanged. The word takes effect from the next `scl_fall` onward.
- R9: A control word loaded while the generator is idle governs the first period after the next start.
- R10: After reset, `scl_o` is high, every strobe is low, and the active control word is zero (s=0, d=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_in | input | 9 | Control word {stretch[5:0], prescale[2:0]} |
| cfg_load | input | 1 | One-cycle request to adopt `cfg_in` |
| run | input | 1 | Master requests SCL periods |
| scl_o | output | 1 | SCL level (high when idle) |
| scl_fall | output | 1 | Strobe: SCL just went low, period start |
| scl_rise | output | 1 | Strobe: SCL just went high |
| sda_chg | output | 1 | Strobe: SDA may change |
| smp_stb | output | 1 | Strobe: sample SDA |

## Verification
The bench measures strobe-to-strobe distances in system cycles for several prescale and stretch pairs, including the maximum stretch with the maximum prescale. These measurements expose a design that treats the period as a plain divide, drops the compensation term, or miscounts the prescaler by one. A control word is changed in the middle of a period. A design that adopts it early shortens or lengthens the running period, and one that loses the pending word repeats the old period afterwards. The start latency from idle and the behaviour when `run` drops mid-period are both checked. A generator that cuts the period short misses its sample strobe, and one that ignores `run` keeps producing falls.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  localparam int CDF_W  = 3;
  localparam int SCGD_W = 6;
  localparam int CFG_W  = CDF_W + SCGD_W;

  typedef struct packed {
    logic [SCGD_W-1:0] stretch;
    logic [CDF_W-1:0]  presc;
  } scl_cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // period length in internal ticks
  function automatic int period_ticks(int stretch, int base, int step, int comp);
    return base + step * stretch + comp;
  endfunction

  function automatic int low_ticks(int per);
    return per / 2;
  endfunction

  function automatic int high_ticks(int per);
    return per - (per / 2);
  endfunction

  // offset of a strobe placed in the middle of a phase
  function automatic int mid_of(int len);
    return len / 2;
  endfunction

  function automatic int max_period(int base, int step, int comp);
    return base + step * ((1 << SCGD_W) - 1) + comp;
  endfunction

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale
  import scl_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CDF_W-1:0] presc,
  output logic             tick
);

  logic [CDF_W-1:0] div_cnt;
  logic             at_top;

  assign at_top = (div_cnt == presc);
  assign tick   = en && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (!en || at_top) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // back-to-back ticks are only legal with a divide of one
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(tick)) |-> (presc == '0)); // R1

endmodule

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
  import scl_gen_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  scl_cfg_t cfg_in,
  input  logic     cfg_load,
  input  logic     apply,
  output scl_cfg_t cfg_act
);

  scl_cfg_t pend_q;
  logic     pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_act <= scl_cfg_t'(RST_CFG);
      pend_q  <= scl_cfg_t'(RST_CFG);
      pend_v  <= 1'b0;
    end else if (apply) begin
      if (cfg_load) begin
        cfg_act <= cfg_in;
      end else if (pend_v) begin
        cfg_act <= pend_q;
      end
      pend_v <= 1'b0;
    end else if (cfg_load) begin
      pend_q <= cfg_in;
      pend_v <= 1'b1;
    end
  end

  // a pending word is never dropped: it is still held until the next apply
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_v) && !$past(apply)) |-> pend_v); // R8

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] sda_pos,
  input  logic [CNT_W-1:0] smp_pos,
  output logic             scl_o,
  output logic             scl_fall,
  output logic             scl_rise,
  output logic             sda_chg,
  output logic             smp_stb,
  output logic             idle,
  output logic             period_start
);

  scl_phase_e       phase;
  logic [CNT_W-1:0] ph_cnt;
  logic [CNT_W-1:0] ph_nxt;
  logic             low_end;
  logic             high_end;

  assign ph_nxt   = ph_cnt + 1'b1;
  assign low_end  = (phase == PH_LOW)  && (ph_nxt == low_len);
  assign high_end = (phase == PH_HIGH) && (ph_nxt == high_len);

  assign period_start = tick && run && ((phase == PH_IDLE) || high_end);
  assign idle  = (phase == PH_IDLE);
  assign scl_o = (phase != PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      ph_cnt   <= '0;
      scl_fall <= 1'b0;
      scl_rise <= 1'b0;
      sda_chg  <= 1'b0;
      smp_stb  <= 1'b0;
    end else begin
      scl_fall <= 1'b0;
      scl_rise <= 1'b0;
      sda_chg  <= 1'b0;
      smp_stb  <= 1'b0;
      if (tick) begin
        unique case (phase)
          PH_IDLE: begin
            if (run) begin
              phase    <= PH_LOW;
              ph_cnt   <= '0;
              scl_fall <= 1'b1;
            end
          end
          PH_LOW: begin
            if (low_end) begin
              phase    <= PH_HIGH;
              ph_cnt   <= '0;
              scl_rise <= 1'b1;
            end else begin
              ph_cnt  <= ph_nxt;
              sda_chg <= (ph_nxt == sda_pos);
            end
          end
          PH_HIGH: begin
            if (high_end) begin
              ph_cnt <= '0;
              if (run) begin
                phase    <= PH_LOW;
                scl_fall <= 1'b1;
              end else begin
                phase <= PH_IDLE;
              end
            end else begin
              ph_cnt  <= ph_nxt;
              smp_stb <= (ph_nxt == smp_pos);
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> (!scl_o && $past(scl_o))); // R3
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (scl_o && !$past(scl_o))); // R3
  AST_SDA_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_chg |-> !scl_o); // R4
  AST_SMP_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> scl_o); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall, scl_rise, sda_chg, smp_stb})); // R5
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> !scl_fall); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (scl_o && !scl_rise && !sda_chg && !smp_stb)); // R7

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int               COMP_F    = 6,
  parameter int               BASE_OVH  = 20,
  parameter int               SCGD_STEP = 8,
  parameter logic [CFG_W-1:0] RST_CFG   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic             cfg_load,
  input  logic             run,
  output logic             scl_o,
  output logic             scl_fall,
  output logic             scl_rise,
  output logic             sda_chg,
  output logic             smp_stb
);

  localparam int MAX_PER = max_period(BASE_OVH, SCGD_STEP, COMP_F);
  localparam int CNT_W   = $clog2(MAX_PER + 1);

  scl_cfg_t         cfg_act;
  logic             tick;
  logic             idle;
  logic             period_start;
  logic             apply;
  logic             pre_en;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] high_len;
  logic [CNT_W-1:0] sda_pos;
  logic [CNT_W-1:0] smp_pos;

  always_comb begin
    int per;
    int lo;
    int hi;
    per      = period_ticks(int'(cfg_act.stretch), BASE_OVH, SCGD_STEP, COMP_F);
    lo       = low_ticks(per);
    hi       = high_ticks(per);
    low_len  = CNT_W'(lo);
    high_len = CNT_W'(hi);
    sda_pos  = CNT_W'(mid_of(lo));
    smp_pos  = CNT_W'(mid_of(hi));
  end

  assign apply  = idle || period_start;
  assign pre_en = run || !idle;

  scl_cfg_hold #(
    .RST_CFG (RST_CFG)
  ) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_in   (scl_cfg_t'(cfg_in)),
    .cfg_load (cfg_load),
    .apply    (apply),
    .cfg_act  (cfg_act)
  );

  scl_prescale i_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (pre_en),
    .presc (cfg_act.presc),
    .tick  (tick)
  );

  scl_phase_seq #(
    .CNT_W (CNT_W)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .run          (run),
    .low_len      (low_len),
    .high_len     (high_len),
    .sda_pos      (sda_pos),
    .smp_pos      (smp_pos),
    .scl_o        (scl_o),
    .scl_fall     (scl_fall),
    .scl_rise     (scl_rise),
    .sda_chg      (sda_chg),
    .smp_stb      (smp_stb),
    .idle         (idle),
    .period_start (period_start)
  );

  // the active word changes mid-run only on the edge that opens a period
  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg_act) && !$past(idle)) |-> scl_fall); // R8
  AST_NO_FALL_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> $past(run)); // R7

endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;

  localparam int F_COMP = 6;

  logic       clk;
  logic       rst_n;
  logic [8:0] cfg_in;
  logic       cfg_load;
  logic       run;
  logic       scl_o, scl_fall, scl_rise, sda_chg, smp_stb;

  int cyc;
  int n_chk;
  int n_err;

  scl_rate_gen #(.COMP_F(F_COMP)) i_scl_rate_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_in   (cfg_in),
    .cfg_load (cfg_load),
    .run      (run),
    .scl_o    (scl_o),
    .scl_fall (scl_fall),
    .scl_rise (scl_rise),
    .sda_chg  (sda_chg),
    .smp_stb  (smp_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 fall, 1 rise, 2 sda change, 3 sample
  task automatic wait_ev(input int sel, output int t);
    t = -1;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if ((sel == 0 && scl_fall) || (sel == 1 && scl_rise) ||
          (sel == 2 && sda_chg) || (sel == 3 && smp_stb)) begin
        t = cyc;
        return;
      end
    end
  endtask

  task automatic load_word(input int s, input int d);
    @(negedge clk);
    cfg_in   = 9'((s << 3) | d);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic stop_and_settle(input int s, input int d);
    run = 1'b0;
    repeat ((20 + 8 * s + F_COMP) * (d + 1) + 20) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(scl_o == 1'b1, "R10 scl level", scl_o, 1);
    chk({scl_fall, scl_rise, sda_chg, smp_stb} == 4'b0, "R10 strobes", {scl_fall, scl_rise, sda_chg, smp_stb}, 0);
  endtask

  // full period check with word (s,d); preload tells whether to load while idle
  task automatic t_period(input int s, input int d, input bit preload, input string tag);
    int p, l, h, k, t_run, t0, t1, t2, t3, t4;
    p = 20 + 8 * s + F_COMP;
    l = p / 2;
    h = p - l;
    k = d + 1;
    if (preload) load_word(s, d);
    @(negedge clk);
    t_run = cyc;
    run = 1'b1;
    wait_ev(0, t0);
    chk(t0 - t_run == k, {tag, " R6 start latency"}, t0 - t_run, k);
    wait_ev(2, t1);
    chk(t1 - t0 == (l / 2) * k, {tag, " R4 sda offset"}, t1 - t0, (l / 2) * k);
    wait_ev(1, t2);
    chk(t2 - t0 == l * k, {tag, " R3 low phase"}, t2 - t0, l * k);
    wait_ev(3, t3);
    chk(t3 - t2 == (h / 2) * k, {tag, " R4 sample offset"}, t3 - t2, (h / 2) * k);
    wait_ev(0, t4);
    chk(t4 - t0 == p * k, {tag, " R1 R2 period"}, t4 - t0, p * k);
    stop_and_settle(s, d);
  endtask

  task automatic t_reload_running;
    int t0, t1, t2, tr;
    load_word(0, 0);
    run = 1'b1;
    wait_ev(0, t0);
    cfg_in   = 9'((1 << 3) | 1);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    wait_ev(1, tr);
    chk(tr - t0 == 13, "R8 current low phase kept", tr - t0, 13);
    wait_ev(0, t1);
    chk(t1 - t0 == 26, "R8 current period kept", t1 - t0, 26);
    wait_ev(0, t2);
    chk(t2 - t1 == 68, "R8 next period uses new word", t2 - t1, 68);
    stop_and_settle(1, 1);
  endtask

  task automatic t_stop;
    int t0, tr, ts, bad;
    load_word(2, 0);
    run = 1'b1;
    wait_ev(0, t0);
    run = 1'b0;
    wait_ev(1, tr);
    chk(tr - t0 == 21, "R7 period completes after run drops", tr - t0, 21);
    wait_ev(3, ts);
    chk(ts - tr == 10, "R7 sample strobe still issued", ts - tr, 10);
    bad = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (!scl_o || scl_fall || scl_rise || sda_chg || smp_stb) bad++;
    end
    chk(bad == 0, "R7 idle keeps SCL high and quiet", bad, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_in = '0;
    cfg_load = 1'b0;
    run = 1'b0;
    cyc = 0;
    n_chk = 0;
    n_err = 0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_period(0, 0, 1'b0, "R10 reset word");
    t_period(5, 2, 1'b1, "R9 idle load");
    t_period(0, 1, 1'b1, "case s0 d1");
    t_period(63, 7, 1'b1, "max word");
    t_reload_running();
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule